// File: doc/BRIEF.md
# Edge-Triggered Port Interrupt Unit

This block watches an 8-bit general-purpose input port and raises an interrupt request when a chosen edge appears on any of its pins. Every pin goes through a two-flop synchroniser. An edge detector compares the synchronised level with the level one clock earlier. A per-pin polarity bit picks rising or falling as the active edge. A detected edge sets a sticky flag for that pin. The flag stays set until software clears it by writing a one to it.

Each flag is gated by a per-pin enable bit. The gated flags are ORed into a single request, which is registered before it leaves the block. A small synchronous register bus reads and writes the enable, polarity and flag registers at any time. Pin 3 is not implemented, so seven channels are active.

Top module: `port_irq_unit`

## Requirements
- R1: After reset the enable (address 0), polarity (address 1) and flag (address 2) registers read 0, and irq_o is 0.
- R2: With polarity bit 0, a falling edge on a pin sets that pin's bit in the flag register within five clocks. A flag that is clear and sees no active edge stays clear.
- R3: With polarity bit 1, a rising edge sets the flag and a falling edge does not. With polarity bit 0, a rising edge does not set the flag.
- R4: Writing 1 to a bit at address 2 clears that flag. Writing 0 leaves the flag unchanged.
- R5: irq_o is 1 one clock after any flag bit and its enable bit are both 1, and is 0 otherwise. A flag whose enable bit is 0 stays readable but raises no request.
- R6: Bit 3 is unimplemented. It reads 0 in all three registers, writes to it are ignored, and edges on pin 3 set no flag and raise no request.
- R7: If an active edge and a write-one-to-clear reach the same flag in the same cycle, the flag stays set.
- R8: Changing a polarity bit while the pin level is steady does not set a flag.
- R9: The enable and polarity registers read back the value last written to their implemented bits. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Asynchronous port pins |
| addr_i | input | 2 | Register address: 0 enable, 1 polarity, 2 flags |
| wr_en_i | input | 1 | Write strobe, sampled on the rising clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for addr_i |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
Edge capture and the software clear both update the flag register, and they can land in the same cycle. To provoke this, the bench raises a pin at a known falling clock edge and counts the synchroniser and edge stages forward. It then places a write of one to that flag in exactly the cycle in which the detected edge is written into the flag. The flag is judged to have survived by reading address 2 afterwards. A separate write-one-to-clear with no edge present is used as the control, and it must clear the flag.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
  localparam int unsigned PIN_W     = 8;
  localparam int unsigned ADDR_W    = 2;
  localparam logic [PIN_W-1:0] IMPL_MASK = 8'hF7;

  typedef enum logic [ADDR_W-1:0] {
    REG_EN   = 2'd0,
    REG_POL  = 2'd1,
    REG_FLAG = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/edge_detect.sv
module edge_detect #(
  parameter int unsigned    WIDTH = 8,
  parameter logic [WIDTH-1:0] MASK = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] pol_i,
  output logic [WIDTH-1:0] edge_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (MASK[i]) begin : g_on
      // changed level, and new level matches polarity (1 rising, 0 falling)
      assign edge_o[i] = (level_i[i] ^ prev_q[i]) & ~(level_i[i] ^ pol_i[i]);
    end else begin : g_off
      assign edge_o[i] = 1'b0;
    end
  end

  // R8
  pol_only_no_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == prev_q) |-> (edge_o == '0));
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int unsigned      WIDTH = 8,
  parameter logic [WIDTH-1:0] MASK  = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] flag_q;

  // set has priority over clear so no event is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= ((flag_q & ~clr_i) | set_i) & MASK;
  end

  assign flag_o = flag_q;

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));

  // R4
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((flag_q & $past(clr_i & ~set_i)) == '0));

  // R2
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_q & $past(~flag_q & ~set_i)) == '0));
endmodule

// File: rtl/port_irq_unit.sv
module port_irq_unit
  import port_irq_pkg::*;
#(
  parameter int unsigned      NUM_PINS    = PIN_W,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [NUM_PINS-1:0] PIN_MASK = IMPL_MASK
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] level;
  logic [NUM_PINS-1:0] edge_hit;
  logic [NUM_PINS-1:0] flag;
  logic [NUM_PINS-1:0] clr_vec;
  logic [NUM_PINS-1:0] en_q;
  logic [NUM_PINS-1:0] pol_q;
  logic                irq_q;
  reg_sel_e            sel;

  assign sel = reg_sel_e'(addr_i);

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (level)
  );

  edge_detect #(.WIDTH(NUM_PINS), .MASK(PIN_MASK)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (level),
    .pol_i   (pol_q),
    .edge_o  (edge_hit)
  );

  assign clr_vec = (wr_en_i && sel == REG_FLAG) ? (wdata_i & PIN_MASK) : '0;

  flag_bank #(.WIDTH(NUM_PINS), .MASK(PIN_MASK)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (edge_hit),
    .clr_i  (clr_vec),
    .flag_o (flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      pol_q <= '0;
    end else if (wr_en_i) begin
      if (sel == REG_EN)  en_q  <= wdata_i & PIN_MASK;
      if (sel == REG_POL) pol_q <= wdata_i & PIN_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flag & en_q);
  end

  assign irq_o = irq_q;

  always_comb begin
    unique case (sel)
      REG_EN:   rdata_o = en_q;
      REG_POL:  rdata_o = pol_q;
      REG_FLAG: rdata_o = flag;
      default:  rdata_o = '0;
    endcase
  end

  // R5
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag & en_q)) |=> irq_o);

  // R5
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flag & en_q)) |=> !irq_o);

  // R6
  unimpl_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((edge_hit | flag | en_q | pol_q) & ~PIN_MASK) == '0);
endmodule

// File: tb/tb_port_irq_unit.sv
module tb_port_irq_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pin_i = '0;
  logic [1:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk_i = ~clk_i;

  port_irq_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // monitor: compares queued expectations 5 ns after the edge
  initial begin
    forever begin
      @(posedge clk_i);
      #5;
      if (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {7'd0, irq_o} : rdata_o;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic chk_reg(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    @(negedge clk_i);
    addr_i = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk_i); #6;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk_i);
    it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    @(posedge clk_i); #6;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic drive_pins(input logic [7:0] v);
    @(negedge clk_i);
    pin_i = v;
    repeat (5) @(posedge clk_i);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 reset state
    chk_reg(2'd0, 8'h00, "R1 enable");
    chk_reg(2'd1, 8'h00, "R1 polarity");
    chk_reg(2'd2, 8'h00, "R1 flags");
    chk_irq(1'b0, "R1 irq");

    // R9 / R6 readback
    wr(2'd0, 8'hFF);
    chk_reg(2'd0, 8'hF7, "R6 enable bit3 ignored");
    wr(2'd0, 8'h5A);
    chk_reg(2'd0, 8'h52, "R9 enable readback");
    wr(2'd0, 8'h00);
    chk_reg(2'd3, 8'h00, "R9 address 3");

    // R8 polarity flips on steady pins
    wr(2'd1, 8'hFF);
    repeat (3) @(posedge clk_i);
    chk_reg(2'd2, 8'h00, "R8 pol to ones");
    wr(2'd1, 8'h00);
    repeat (3) @(posedge clk_i);
    chk_reg(2'd2, 8'h00, "R8 pol to zeros");
    wr(2'd1, 8'h05);
    chk_reg(2'd1, 8'h05, "R9 polarity readback");

    // R3 rising on pin0, R2 falling on pin1
    drive_pins(8'h01);
    chk_reg(2'd2, 8'h01, "R3 rising sets pin0");
    drive_pins(8'h03);
    chk_reg(2'd2, 8'h01, "R3 rising ignored on falling pin1");
    drive_pins(8'h01);
    chk_reg(2'd2, 8'h03, "R2 falling sets pin1");

    // R4 write-one-to-clear
    wr(2'd2, 8'h02);
    chk_reg(2'd2, 8'h01, "R4 clear pin1");
    wr(2'd2, 8'h00);
    chk_reg(2'd2, 8'h01, "R4 write zero no effect");
    wr(2'd2, 8'h01);
    chk_reg(2'd2, 8'h00, "R4 clear pin0");

    // R6 pin3 edges ignored
    wr(2'd0, 8'hFF);
    drive_pins(8'h09);
    drive_pins(8'h01);
    chk_reg(2'd2, 8'h00, "R6 pin3 no flag");
    chk_irq(1'b0, "R6 pin3 no irq");
    wr(2'd0, 8'h00);

    // R5 masking
    drive_pins(8'h11);
    drive_pins(8'h01);
    chk_reg(2'd2, 8'h10, "R5 masked flag visible");
    chk_irq(1'b0, "R5 masked no irq");
    wr(2'd0, 8'h10);
    chk_irq(1'b1, "R5 enabled irq");
    wr(2'd0, 8'h20);
    chk_irq(1'b0, "R5 other enable no irq");
    wr(2'd0, 8'h10);
    wr(2'd2, 8'h10);
    chk_irq(1'b0, "R5 irq drops after clear");
    chk_reg(2'd2, 8'h00, "R4 flags empty");

    // R7 collision on pin0 (rising polarity)
    drive_pins(8'h00);
    chk_reg(2'd2, 8'h00, "R3 falling ignored on rising pin0");
    @(negedge clk_i);
    pin_i = 8'h01;
    @(posedge clk_i);            // first sync stage
    @(posedge clk_i);            // synchronised level, edge visible
    @(negedge clk_i);
    addr_i = 2'd2; wdata_i = 8'h01; wr_en_i = 1'b1;
    @(posedge clk_i);            // flag set and clear together
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk_reg(2'd2, 8'h01, "R7 edge beats clear");
    wr(2'd2, 8'h01);
    chk_reg(2'd2, 8'h00, "R7 control clear");

    repeat (2) @(posedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule